// File: doc/BRIEF.md
# Configuration Access Bridge

This block lets a host processor reach the configuration registers of devices on an expansion bus through two 32-bit I/O ports. Software first writes a target selector (enable flag, bus, device, function and dword index) into an address port. Reads and writes of a second data port then become configuration read and write cycles on a downstream request/response link. The target answers with a completion that carries a status flag and read data.

Each function has a 256-byte configuration space, addressed as 64 dwords. Every access is a full dword, so the two lowest selector bits are always zero. Bus 0 is served with a local (type 0) cycle. Any other bus number gets a forwarded (type 1) cycle. When a target is absent, signals an error or never answers, reads return all ones. Enumeration software takes that value to mean that no device is present. Only one access is handled at a time: the I/O side is held off until the current cycle has finished.

Top module: `cfg_access_bridge`

## Requirements
- R1: After reset the selector register reads as 0x00000000, `io_ready_o` is low and `cfg_req_o` is low.
- R2: A write to the address port (0xCF8) stores the value with bits 30:24 and 1:0 forced to zero. A read of that port returns the stored value.
- R3: While selector bit 31 is 0, a data port (0xCFC) access issues no downstream request. A read returns 0xFFFFFFFF and a write is dropped.
- R4: During a request, `cfg_bus_o` carries selector bits 23:16, `cfg_dev_o` bits 15:11, `cfg_func_o` bits 10:8 and `cfg_reg_o` bits 7:2. These stay stable until the request ends.
- R5: `cfg_type1_o` is 0 when the bus field is 0 and 1 for any other bus number.
- R6: When bit 31 is 1, each data port access issues exactly one request. `cfg_we_o` is 1 for a write, and `cfg_wdata_o` carries the written value. A successful completion (`cfg_rsp_ok_i`=1) of a read returns `cfg_rsp_data_i` on `io_rdata_o`, and `io_ready_o` follows in the cycle after the request drops.
- R7: A completion with `cfg_rsp_ok_i`=0 makes a read return 0xFFFFFFFF.
- R8: If no completion arrives, `cfg_req_o` stays high for exactly 64 cycles and is then withdrawn. A read returns 0xFFFFFFFF, and `io_ready_o` is still given.
- R9: `io_ready_o` is a single-cycle pulse, given once per access. It is not given before the downstream cycle completes or times out.
- R10: An access to any other I/O address gets `io_ready_o`. A read returns 0xFFFFFFFF, and no request or selector change results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 16 | I/O port address |
| io_wdata_i | input | 32 | I/O write data |
| io_rd_i | input | 1 | I/O read strobe, held until ready |
| io_wr_i | input | 1 | I/O write strobe, held until ready |
| io_rdata_o | output | 32 | I/O read data, valid with ready |
| io_ready_o | output | 1 | One-cycle access completion |
| cfg_req_o | output | 1 | Configuration request, held until completion or timeout |
| cfg_we_o | output | 1 | 1 = configuration write |
| cfg_type1_o | output | 1 | 1 = forwarded cycle, 0 = local cycle |
| cfg_bus_o | output | 8 | Bus number |
| cfg_dev_o | output | 5 | Device number |
| cfg_func_o | output | 3 | Function number |
| cfg_reg_o | output | 6 | Dword register index |
| cfg_wdata_o | output | 32 | Configuration write data |
| cfg_rsp_i | input | 1 | Completion pulse |
| cfg_rsp_ok_i | input | 1 | Completion status, 1 = success |
| cfg_rsp_data_i | input | 32 | Completion read data |

## Verification
The assertions check four things on every cycle:
- no request is raised while the enable bit is clear;
- the target fields hold steady for the whole request;
- a request never lasts past the timeout window;
- the ready pulse is a single cycle and follows the withdrawal of a request.

Only the bench's scenarios can show the data path itself. That covers the read values for present, erroring and silent targets, the local/forwarded choice across the device and bus sweep, the masking of reserved selector bits, and the all-ones answers for disabled or foreign-port accesses.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;
  localparam int          DW            = 32;
  localparam logic [31:0] SEL_WR_MASK   = 32'h80FF_FFFC;
  localparam logic [31:0] NO_DEVICE     = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DONE} ctrl_state_e;
  typedef enum logic [1:0] {PORT_NONE, PORT_SEL, PORT_DATA} port_sel_e;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] reg_idx;
  } cfg_target_t;
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_bridge_pkg::*;
#(
  parameter int IO_AW     = 16,
  parameter int SEL_PORT  = 'hCF8,
  parameter int DATA_PORT = 'hCFC
) (
  input  logic [IO_AW-1:0] addr_i,
  output port_sel_e        sel_o
);
  always_comb begin
    if (addr_i == IO_AW'(SEL_PORT))       sel_o = PORT_SEL;
    else if (addr_i == IO_AW'(DATA_PORT)) sel_o = PORT_DATA;
    else                                  sel_o = PORT_NONE;
  end
endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_bridge_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] sel_q_o,
  output cfg_target_t   tgt_o
);
  logic [DW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= '0;
    else if (wr_i) sel_q <= wdata_i & SEL_WR_MASK;
  end

  assign sel_q_o       = sel_q;
  assign tgt_o.en      = sel_q[31];
  assign tgt_o.bus     = sel_q[23:16];
  assign tgt_o.dev     = sel_q[15:11];
  assign tgt_o.func    = sel_q[10:8];
  assign tgt_o.reg_idx = sel_q[7:2];
endmodule

// File: rtl/cfg_cycle_ctrl.sv
module cfg_cycle_ctrl
  import cfg_bridge_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  port_sel_e     port_i,
  input  logic          en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] sel_q_i,
  output logic          sel_wr_o,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o,
  output logic          req_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  input  logic          rsp_i,
  input  logic          rsp_ok_i,
  input  logic [DW-1:0] rsp_data_i
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

  ctrl_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rdata_q, rdata_d, wdata_q, wdata_d;
  logic          we_q, we_d;
  logic          io_req;

  assign io_req = rd_i | wr_i;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    rdata_d  = rdata_q;
    wdata_d  = wdata_q;
    we_d     = we_q;
    sel_wr_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (io_req) begin
        state_d = ST_DONE;
        rdata_d = NO_DEVICE;
        unique case (port_i)
          PORT_SEL: begin
            sel_wr_o = wr_i;
            if (!wr_i) rdata_d = sel_q_i;
          end
          PORT_DATA: if (en_i) begin
            state_d = ST_REQ;
            cnt_d   = '0;
            we_d    = wr_i;
            wdata_d = wdata_i;
          end
          default: ;
        endcase
      end
      ST_REQ: begin
        if (rsp_i) begin
          state_d = ST_DONE;
          rdata_d = (!we_q && rsp_ok_i) ? rsp_data_i : NO_DEVICE;
        end else if (cnt_q == CNT_LAST) begin
          state_d = ST_DONE;          // master abort
          rdata_d = NO_DEVICE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rdata_q <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rdata_q <= rdata_d;
      wdata_q <= wdata_d;
      we_q    <= we_d;
    end
  end

  assign req_o   = (state_q == ST_REQ);
  assign ready_o = (state_q == ST_DONE);
  assign rdata_o = rdata_q;
  assign we_o    = we_q;
  assign wdata_o = wdata_q;

  assert_ready_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  assert_ready_after_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> ready_o);
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
  import cfg_bridge_pkg::*;
#(
  parameter int IO_AW     = 16,
  parameter int SEL_PORT  = 'hCF8,
  parameter int DATA_PORT = 'hCFC,
  parameter int TIMEOUT   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic [31:0]      io_wdata_i,
  input  logic             io_rd_i,
  input  logic             io_wr_i,
  output logic [31:0]      io_rdata_o,
  output logic             io_ready_o,
  output logic             cfg_req_o,
  output logic             cfg_we_o,
  output logic             cfg_type1_o,
  output logic [7:0]       cfg_bus_o,
  output logic [4:0]       cfg_dev_o,
  output logic [2:0]       cfg_func_o,
  output logic [5:0]       cfg_reg_o,
  output logic [31:0]      cfg_wdata_o,
  input  logic             cfg_rsp_i,
  input  logic             cfg_rsp_ok_i,
  input  logic [31:0]      cfg_rsp_data_i
);
  localparam int RW = $clog2(TIMEOUT) + 1;

  port_sel_e     port_sel;
  cfg_target_t   tgt;
  logic [DW-1:0] sel_q;
  logic          sel_wr;

  cfg_port_decode #(.IO_AW(IO_AW), .SEL_PORT(SEL_PORT), .DATA_PORT(DATA_PORT)) u_decode (
    .addr_i (io_addr_i),
    .sel_o  (port_sel)
  );

  cfg_addr_reg u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (sel_wr),
    .wdata_i (io_wdata_i),
    .sel_q_o (sel_q),
    .tgt_o   (tgt)
  );

  cfg_cycle_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (io_rd_i),
    .wr_i       (io_wr_i),
    .port_i     (port_sel),
    .en_i       (tgt.en),
    .wdata_i    (io_wdata_i),
    .sel_q_i    (sel_q),
    .sel_wr_o   (sel_wr),
    .rdata_o    (io_rdata_o),
    .ready_o    (io_ready_o),
    .req_o      (cfg_req_o),
    .we_o       (cfg_we_o),
    .wdata_o    (cfg_wdata_o),
    .rsp_i      (cfg_rsp_i),
    .rsp_ok_i   (cfg_rsp_ok_i),
    .rsp_data_i (cfg_rsp_data_i)
  );

  assign cfg_bus_o   = tgt.bus;
  assign cfg_dev_o   = tgt.dev;
  assign cfg_func_o  = tgt.func;
  assign cfg_reg_o   = tgt.reg_idx;
  assign cfg_type1_o = (tgt.bus != 8'd0);

  // length of the current request, for the timeout bound
  logic [RW-1:0] req_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         req_run_q <= '0;
    else if (!cfg_req_o) req_run_q <= '0;
    else                 req_run_q <= req_run_q + 1'b1;
  end

  assert_req_bounded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> (req_run_q < RW'(TIMEOUT)));
  assert_req_needs_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> sel_q[31]);
  assert_fields_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |=> (!cfg_req_o || $stable({cfg_bus_o, cfg_dev_o, cfg_func_o, cfg_reg_o, cfg_type1_o})));
endmodule

// File: tb/cfg_access_bridge_tb.sv
`timescale 1ns/1ps
module cfg_access_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [31:0] io_wdata = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [31:0] io_rdata;
  logic        io_ready;
  logic        cfg_req, cfg_we, cfg_type1;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_reg;
  logic [31:0] cfg_wdata;
  logic        rsp = 1'b0, rsp_ok = 1'b0;
  logic [31:0] rsp_data = '0;

  int checks = 0, errors = 0;
  int req_count = 0, cur_len = 0, wait_cnt = 0;
  logic prev_req = 1'b0;
  logic [7:0] l_bus; logic [4:0] l_dev; logic [2:0] l_func; logic [5:0] l_reg;
  logic l_we, l_type1; logic [31:0] l_wdata;

  always #5 clk = ~clk;

  cfg_access_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wdata_i(io_wdata),
    .io_rd_i(io_rd), .io_wr_i(io_wr), .io_rdata_o(io_rdata), .io_ready_o(io_ready),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_type1_o(cfg_type1),
    .cfg_bus_o(cfg_bus), .cfg_dev_o(cfg_dev), .cfg_func_o(cfg_func), .cfg_reg_o(cfg_reg),
    .cfg_wdata_o(cfg_wdata), .cfg_rsp_i(rsp), .cfg_rsp_ok_i(rsp_ok), .cfg_rsp_data_i(rsp_data)
  );

  function automatic logic [31:0] mk_sel(input logic en, input logic [7:0] b,
                                         input logic [4:0] d, input logic [2:0] f, input logic [5:0] r);
    return {en, 7'h00, b, d, f, r, 2'b00};
  endfunction

  function automatic logic [31:0] dev_data(input logic [7:0] b, input logic [4:0] d,
                                           input logic [2:0] f, input logic [5:0] r);
    return {2'b10, b, d, f, r, 8'h3C};
  endfunction

  // target model: dev<24 answers ok, 24..30 answers with error, 31 never answers
  always @(negedge clk) begin
    if (rsp) begin
      rsp = 1'b0;
    end else if (cfg_req) begin
      if (!prev_req) begin
        req_count++; cur_len = 0; wait_cnt = 0;
        l_bus = cfg_bus; l_dev = cfg_dev; l_func = cfg_func; l_reg = cfg_reg;
        l_we = cfg_we; l_wdata = cfg_wdata; l_type1 = cfg_type1;
      end
      cur_len++;
      if (cfg_dev != 5'd31) begin
        if (wait_cnt == int'(cfg_dev % 4)) begin
          rsp = 1'b1; rsp_ok = (cfg_dev < 5'd24);
          rsp_data = dev_data(cfg_bus, cfg_dev, cfg_func, cfg_reg);
        end else wait_cnt++;
      end
    end
    prev_req = cfg_req;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic io_op(input logic [15:0] a, input logic wr, input logic [31:0] wd,
                       output logic [31:0] rd, output int waited);
    @(negedge clk);
    io_addr = a; io_wdata = wd; io_rd = !wr; io_wr = wr; waited = 0;
    do begin @(negedge clk); waited++; end while (!io_ready);
    rd = io_rdata; io_rd = 1'b0; io_wr = 1'b0;
    @(negedge clk);
    chk("R9 ready single pulse", {31'b0, io_ready}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd, sel;
    int w, rc;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ready", {31'b0, io_ready}, 32'h0);
    chk("R1 req", {31'b0, cfg_req}, 32'h0);
    rst_n = 1'b1;
    io_op(16'hCF8, 1'b0, '0, rd, w);
    chk("R1 selector", rd, 32'h0);

    // R3: disabled selector
    io_op(16'hCF8, 1'b1, mk_sel(1'b0, 8'd0, 5'd1, 3'd0, 6'd0), rd, w);
    rc = req_count;
    io_op(16'hCFC, 1'b0, '0, rd, w);
    chk("R3 read ones", rd, 32'hFFFF_FFFF);
    io_op(16'hCFC, 1'b1, 32'h1234_5678, rd, w);
    chk("R3 no request", req_count, rc);

    // R10: foreign ports
    sel = mk_sel(1'b1, 8'd2, 5'd3, 3'd4, 6'd5);
    io_op(16'hCF8, 1'b1, sel, rd, w);
    io_op(16'hCFA, 1'b0, '0, rd, w);
    chk("R10 read ones", rd, 32'hFFFF_FFFF);
    io_op(16'hCF9, 1'b1, 32'h0, rd, w);
    io_op(16'h0080, 1'b1, 32'hDEAD_BEEF, rd, w);
    io_op(16'hCF8, 1'b0, '0, rd, w);
    chk("R10 selector unchanged", rd, sel);
    chk("R10 no request", req_count, rc);

    // sweep over buses, devices, functions, register indices
    foreach (sel[i]) if (i < 2) begin
      logic [7:0] b = (i == 0) ? 8'd0 : 8'd5;
      for (int d = 0; d < 32; d++) begin
        logic [2:0] f = 3'((d + int'(b)) % 8);
        logic [5:0] r = 6'((d * 5 + int'(b)) % 64);
        logic [31:0] exp;
        sel = mk_sel(1'b1, b, 5'(d), f, r);
        io_op(16'hCF8, 1'b1, sel | 32'h7F00_0003, rd, w);
        io_op(16'hCF8, 1'b0, '0, rd, w);
        chk("R2 masked readback", rd, sel);
        rc = req_count;
        io_op(16'hCFC, 1'b0, '0, rd, w);
        chk("R6 one request", req_count, rc + 1);
        chk("R4 fields", {l_bus, 3'b0, l_dev, 5'b0, l_func, 2'b0, l_reg},
            {b, 3'b0, 5'(d), 5'b0, f, 2'b0, r});
        chk("R5 cycle type", {31'b0, l_type1}, {31'b0, (b != 8'd0)});
        chk("R6 read flag", {31'b0, l_we}, 32'h0);
        if (d < 24) begin
          exp = dev_data(b, 5'(d), f, r);
          chk("R6 read data", rd, exp);
          chk("R9 waits for completion", {31'b0, (w >= d % 4 + 2)}, 32'h1);
        end else if (d < 31) begin
          chk("R7 error reads ones", rd, 32'hFFFF_FFFF);
        end else begin
          chk("R8 timeout reads ones", rd, 32'hFFFF_FFFF);
          chk("R8 request length", cur_len, 64);
          chk("R9 ready after abort", {31'b0, (w >= 65)}, 32'h1);
        end
        if (d < 4 || d == 31) begin
          io_op(16'hCFC, 1'b1, ~sel, rd, w);
          chk("R6 write request", req_count, rc + 2);
          chk("R6 write flag", {31'b0, l_we}, 32'h1);
          chk("R6 write data", l_wdata, ~sel);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule